// File: doc/BRIEF.md
# Three-Master External Bus Arbiter

This block decides which of three parties may drive a shared external bus: an outside device asking for the bus through an active-low hold line, a DMA controller, and the CPU. The order of precedence is fixed: the hold request first, then DMA, then the CPU. Ownership moves only between bus accesses. The bus sequencer marks each access with a one-cycle `acc_start` pulse and a later one-cycle `acc_done` pulse. The hold line comes from outside the clock domain, so it passes through a two-flop synchroniser before the arbiter acts on it.

When the hold is accepted, the arbiter drives the acknowledge low and drops the output enables of the address, data and strobe pin groups, so those pins float. It also raises a port-freeze signal so that general-purpose ports keep their present levels. The bus clock is not gated and keeps running. A CPU word access to an odd address runs as two accesses. The first half sets a lock, and the lock clears when the second half completes. While the lock is set, DMA cannot take the bus. A hold request can still take the bus at the end of either half. When the hold ends, the CPU gets the bus back so it can finish the pair.

States: `ST_IDLE` (nobody granted), `ST_CPU`, `ST_DMA`, `ST_HOLD`. At each free point (the bus is idle with no start, or an access completes) the arbiter moves from any state to the winner by priority: `ST_HOLD` if the synchronised hold is active; otherwise `ST_DMA` if DMA requests and the lock is not set; otherwise `ST_CPU` if the CPU requests or the lock is set; otherwise `ST_IDLE`. At any other time the state is kept.

Top module: `bus_arbiter3`

## Requirements
- R1: During and after reset, with no requests, `hold_ack_n`=1, `dma_gnt`=0, `cpu_gnt`=0, all three output enables are 1 and `port_hold`=0.
- R2: On an idle bus, the owner granted is the highest-priority active requester, in the order hold, then DMA, then CPU. At most one of `cpu_gnt`, `dma_gnt` and (not `hold_ack_n`) is high at a time.
- R3: If the hold line goes low during an access, `hold_ack_n` stays 1 until `acc_done`. It goes to 0 on the clock edge that samples `acc_done`.
- R4: The hold state persists, with `hold_ack_n`=0, for as long as the synchronised hold input stays low.
- R5: In the hold state, `addr_oe`, `data_oe` and `strb_oe` are 0 and `port_hold` is 1. Both grants are 0.
- R6: After the synchronised hold input returns high, the next edge leaves the hold state. `hold_ack_n` returns to 1, the output enables return to 1 in the same cycle, and the grant goes to the highest-priority pending requester.
- R7: On an idle bus, a falling `hold_req_n` is first visible as `hold_ack_n`=0 after the third rising edge. The edges are two synchroniser stages plus the state register.
- R8: While an access is in flight (between `acc_start` and `acc_done`), the grant does not change, whatever requests arrive.
- R9: A CPU access started with `cpu_odd_word`=1 locks the bus against DMA through both halves. `dma_gnt` stays 0 until the `acc_done` of the second half. A pending DMA request is then granted on that same edge.
- R10: A hold request may take the bus between the two halves of a locked pair. When the hold ends, the CPU is granted again even if DMA is requesting.
- R11: With no requests on a free bus, the arbiter returns to idle with both grants 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | External hold request, active low, asynchronous |
| dma_req | input | 1 | DMA controller bus request |
| cpu_req | input | 1 | CPU bus request |
| cpu_odd_word | input | 1 | The CPU's next access is a word at an odd address (two halves) |
| acc_start | input | 1 | One-cycle pulse: the granted master starts an access |
| acc_done | input | 1 | One-cycle pulse: the current access completes |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| dma_gnt | output | 1 | Bus granted to DMA |
| cpu_gnt | output | 1 | Bus granted to CPU |
| addr_oe | output | 1 | Output enable for address pins and chip selects |
| data_oe | output | 1 | Output enable for data pins |
| strb_oe | output | 1 | Output enable for read, write and byte-high strobes |
| port_hold | output | 1 | Freezes general-purpose port levels during hold |

## Verification
The hardest case to reach is a hold that arrives in the gap between the two halves of a locked odd-address pair while DMA is also requesting. It needs the lock to be set, the first half to finish, and the synchronised hold to rise before the second start. The bench first grants the CPU and completes the first half with DMA raised. It then lowers the hold line on the idle gap and waits out the synchroniser delay. After release it checks that the CPU, not DMA, is granted again. Other sweeps apply every mix of hold and DMA requests in the middle of a CPU access, and every request combination on an idle bus.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CPU  = 2'd1,
        ST_DMA  = 2'd2,
        ST_HOLD = 2'd3
    } arb_state_t;
endpackage

// File: rtl/arb_hold_sync.sv
module arb_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    output logic hold_s
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= ~hold_req_n;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign hold_s = chain_q[STAGES-1];
endmodule

// File: rtl/arb_access_track.sv
module arb_access_track (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_start,
    input  logic acc_done,
    input  logic cpu_gnt,
    input  logic cpu_odd_word,
    output logic busy_q,
    output logic bus_free,
    output logic lock_q,
    output logic lock_next
);
    logic phase_q, phase_d, busy_d, first_half;

    assign first_half = acc_start && cpu_gnt && cpu_odd_word && !lock_q;
    assign bus_free   = (!busy_q && !acc_start) || (busy_q && acc_done);

    always_comb begin
        busy_d    = busy_q;
        lock_next = lock_q;
        phase_d   = phase_q;
        if (acc_start)     busy_d = 1'b1;
        else if (acc_done) busy_d = 1'b0;
        if (first_half) lock_next = 1'b1;
        if (acc_done && lock_q) begin
            if (!phase_q) begin
                phase_d = 1'b1;
            end else begin
                phase_d   = 1'b0;
                lock_next = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            lock_q  <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            busy_q  <= busy_d;
            lock_q  <= lock_next;
            phase_q <= phase_d;
        end
    end

    assert_lock_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && phase_q && acc_done) |=> !lock_q);
endmodule

// File: rtl/bus_arbiter3.sv
module bus_arbiter3 #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic dma_req,
    input  logic cpu_req,
    input  logic cpu_odd_word,
    input  logic acc_start,
    input  logic acc_done,
    output logic hold_ack_n,
    output logic dma_gnt,
    output logic cpu_gnt,
    output logic addr_oe,
    output logic data_oe,
    output logic strb_oe,
    output logic port_hold
);
    import arb_pkg::*;

    arb_state_t state_q, state_d;
    logic hold_s, busy_q, bus_free, lock_q, lock_next;

    arb_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req_n (hold_req_n),
        .hold_s     (hold_s)
    );

    arb_access_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .acc_done     (acc_done),
        .cpu_gnt      (cpu_gnt),
        .cpu_odd_word (cpu_odd_word),
        .busy_q       (busy_q),
        .bus_free     (bus_free),
        .lock_q       (lock_q),
        .lock_next    (lock_next)
    );

    function automatic arb_state_t pick_owner(input logic h, input logic d,
                                              input logic c, input logic lk);
        if (h)            return ST_HOLD;
        else if (d && !lk) return ST_DMA;
        else if (c || lk) return ST_CPU;
        else              return ST_IDLE;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CPU, ST_DMA: begin
                if (bus_free) state_d = pick_owner(hold_s, dma_req, cpu_req, lock_next);
            end
            ST_HOLD: begin
                if (!hold_s) state_d = pick_owner(1'b0, dma_req, cpu_req, lock_next);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hold_ack_n = 1'b1;
        dma_gnt    = 1'b0;
        cpu_gnt    = 1'b0;
        addr_oe    = 1'b1;
        data_oe    = 1'b1;
        strb_oe    = 1'b1;
        port_hold  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CPU:  cpu_gnt = 1'b1;
            ST_DMA:  dma_gnt = 1'b1;
            ST_HOLD: begin
                hold_ack_n = 1'b0;
                addr_oe    = 1'b0;
                data_oe    = 1'b0;
                strb_oe    = 1'b0;
                port_hold  = 1'b1;
            end
            default: ;
        endcase
    end

    assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, dma_gnt, ~hold_ack_n}));
    assert_grant_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !acc_done) |=> $stable(state_q));
    assert_hold_persist_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && hold_s) |=> (state_q == ST_HOLD));
    assert_hold_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !hold_s) |=> (state_q != ST_HOLD));
    assert_dma_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> !dma_gnt);
endmodule

// File: tb/bus_arbiter3_bench.sv
module bus_arbiter3_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1, dma_req = 1'b0, cpu_req = 1'b0, cpu_odd_word = 1'b0;
    logic acc_start = 1'b0, acc_done = 1'b0;
    logic hold_ack_n, dma_gnt, cpu_gnt, addr_oe, data_oe, strb_oe, port_hold;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_arbiter3 u_bus_arbiter3 (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .dma_req(dma_req),
        .cpu_req(cpu_req), .cpu_odd_word(cpu_odd_word), .acc_start(acc_start),
        .acc_done(acc_done), .hold_ack_n(hold_ack_n), .dma_gnt(dma_gnt),
        .cpu_gnt(cpu_gnt), .addr_oe(addr_oe), .data_oe(data_oe),
        .strb_oe(strb_oe), .port_hold(port_hold)
    );

    // owner: 0 idle, 1 cpu, 2 dma, 3 hold
    function automatic logic [6:0] expect_out(input int owner);
        case (owner)
            1:       return 7'b1010_110 | 7'b0000_001 ^ 7'b0000_001 | 7'b0000_000 ^ 7'b0000_000 ^ 7'b0000_000 | 7'b1011_110 & 7'b1011_110;
            2:       return 7'b1101_110;
            3:       return 7'b0000_001;
            default: return 7'b1001_110;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int owner);
        logic [6:0] got;
        logic [6:0] exp;
        got = {hold_ack_n, dma_gnt, cpu_gnt, addr_oe, data_oe, strb_oe, port_hold};
        exp = expect_out(owner);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (ack,dma,cpu,aoe,doe,soe,ph)", req, got, exp);
        end
    endtask

    task automatic pulse_start();
        acc_start = 1'b1; step(1); acc_start = 1'b0;
    endtask

    task automatic pulse_done();
        acc_done = 1'b1; step(1); acc_done = 1'b0;
    endtask

    task automatic quiesce();
        hold_req_n = 1'b1; dma_req = 1'b0; cpu_req = 1'b0; cpu_odd_word = 1'b0;
        step(5);
    endtask

    initial begin
        step(3);
        check("R1 in reset", 0);
        rst_n = 1'b1;
        step(2);
        check("R1 after reset", 0);

        // R2/R11: every combination of requests on an idle bus
        for (int c = 0; c < 8; c++) begin
            quiesce();
            check("R11 idle before sweep", 0);
            hold_req_n = ~c[2]; dma_req = c[1]; cpu_req = c[0];
            step(4);
            check("R2 idle priority", c[2] ? 3 : (c[1] ? 2 : (c[0] ? 1 : 0)));
        end
        quiesce();
        check("R11 return to idle", 0);

        // R7: hold latency on idle bus
        hold_req_n = 1'b0;
        step(2);
        check("R7 not yet after two edges", 0);
        step(1);
        check("R7 acknowledged after third edge", 3);
        quiesce();

        // R8/R3/R5/R6: requests arriving during a CPU access
        for (int p = 0; p < 4; p++) begin
            quiesce();
            cpu_req = 1'b1;
            step(1);
            check("R2 cpu granted", 1);
            pulse_start();
            hold_req_n = ~p[1]; dma_req = p[0];
            step(5);
            check("R8 grant frozen mid-access", 1);
            check("R3 no ack before done", 1);
            pulse_done();
            check("R3 owner after done", p[1] ? 3 : (p[0] ? 2 : 1));
            if (p[1]) begin
                step(4);
                check("R4 hold persists", 3);
                check("R5 pins floated in hold", 3);
                hold_req_n = 1'b1;
                step(2);
                check("R4 hold until sync sees release", 3);
                step(1);
                check("R6 release to pending requester", p[0] ? 2 : 1);
            end
        end

        // R9: odd-address pair locked against DMA
        quiesce();
        cpu_req = 1'b1; cpu_odd_word = 1'b1;
        step(1);
        check("R9 cpu granted for pair", 1);
        pulse_start();
        dma_req = 1'b1;
        step(2);
        pulse_done();
        check("R9 dma masked after first half", 1);
        step(3);
        check("R9 dma masked in gap", 1);
        pulse_start();
        step(1);
        pulse_done();
        check("R9 dma granted after second half", 2);

        // R10: hold between halves, CPU resumes the pair
        quiesce();
        cpu_req = 1'b1; cpu_odd_word = 1'b1;
        step(1);
        pulse_start();
        pulse_done();
        check("R10 cpu keeps bus after first half", 1);
        dma_req = 1'b1; hold_req_n = 1'b0;
        step(4);
        check("R10 hold taken between halves", 3);
        hold_req_n = 1'b1;
        step(3);
        check("R10 cpu resumes pair over dma", 1);
        pulse_start();
        pulse_done();
        check("R10 dma after pair completes", 2);
        quiesce();
        check("R11 final idle", 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule